// File: doc/BRIEF.md
# Bidirectional GPIO Port Bank

This block is a bank of small bidirectional digital ports for a microcontroller core. Every port is a group of pins, and each pin has one output latch bit and one direction bit. A software-style register bus reaches the bank. It has a one-cycle write strobe and a combinational read. Each port exposes a data register at even address `2*p` and a direction register at odd address `2*p+1`.

The pad side is split into three vectors: a pin level coming in, a driven value going out, and an output enable. The pin level passes through a two-flop synchronizer before it reaches the read path. One bit of the bank can be chosen as an open-drain pin. Any bit can be handed to a peripheral through a per-bit override, and the peripheral then supplies that pad's enable and value.

A read of a data register returns a different source for each bit. An output bit returns its latch. An input bit, or a bit under override, returns the synchronized pin. A read-modify-write of a port that mixes both kinds of bit therefore copies pin levels into the latches of the input bits.

Top module: `gpio_bank`

## Requirements
- R1: After reset every direction bit and every latch bit is 0, so every pad has padOe=0 and padOut=0, and every register reads 0 while the pins are low.
- R2: The direction register of port p is at address 2p+1. Bit value 1 selects output and sets padOe for that pin one cycle after the write. Bit value 0 selects input and clears padOe. This applies to pins that are not open-drain and not overridden.
- R3: Reading the data register (address 2p) returns, for each bit in output mode, the value of that bit's output latch.
- R4: For each input-mode bit, a data register read returns the pin level sampled two clock edges earlier by a two-flop synchronizer. No input latch is kept.
- R5: The data latch can be written in any direction mode. padOut of a push-pull pin always shows its latch. Switching a pin from input to output after the latch is loaded leaves padOut unchanged while padOe rises.
- R6: A read of a port followed by a write-back of the value read loads each input bit's latch with the pin level that was read.
- R7: The open-drain pin (global bit index OD_BIT, default 1 = port 0 bit 1) is only ever driven to 0. It has padOe=1 and padOut=0 when in output mode with latch 0, and padOe=0 when its latch is 1 or it is an input. A read returns its latch while it is an output.
- R8: When altEn[i]=1, padOe[i] and padOut[i] equal altOe[i] and altOut[i], regardless of the latch and direction of that pin.
- R9: A data register read of a bit with altEn=1 returns the synchronized pin level, even if its direction bit is 1.
- R10: Reading the direction register returns the last value written to it.
- R11: Writes to addresses at or above 2*NUM_PORTS change no latch, direction bit or pad, and reads from those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Single-cycle register write strobe |
| addr | input | ADDR_W | Register address (data 2p, direction 2p+1) |
| wrData | input | PORT_W | Write data |
| rdData | output | PORT_W | Combinational read data for addr |
| padIn | input | NUM_PORTS*PORT_W | Pin levels from the pads |
| padOut | output | NUM_PORTS*PORT_W | Value driven to the pads |
| padOe | output | NUM_PORTS*PORT_W | Pad output enable |
| altEn | input | NUM_PORTS*PORT_W | Per-bit peripheral override enable |
| altOe | input | NUM_PORTS*PORT_W | Peripheral output enable |
| altOut | input | NUM_PORTS*PORT_W | Peripheral output value |

## Verification
The bench sweeps every direction value against every latch value on every port, with a pin pattern that differs from the latch. A design that chose the read source by register rather than per bit, or that inverted the direction encoding, shows miscompares there. A mixed-direction port is read and written back. This confirms that input bits pick up the pin level, so a design that preserved the old latch for input bits fails the check. Further checks cover the rest. Synchronizer latency is checked one and two edges after a pin change, so a design with one flop or three fails. Loading the latch and then raising the direction bit must leave padOut unchanged, so a design that gated padOut with direction fails. The open-drain pin must never drive high. Overridden pins are checked on both the drive side and the read side. Out-of-range writes must leave every pad and register untouched.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  // strobes from address decode to the datapath
  typedef struct packed {
    logic wrData;   // write hits a data latch register
    logic wrDir;    // write hits a direction register
    logic rdDir;    // read selects the direction register
    logic rdValid;  // address lies inside the map
  } gpioStrobe_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int ADDR_W    = 3
) (
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    addr,
  output gpioStrobe_t          stb,
  output logic [NUM_PORTS-1:0] portSel
);
  localparam int NUM_REGS = 2 * NUM_PORTS;

  logic inRange;

  always_comb begin
    inRange = (addr < ADDR_W'(NUM_REGS));
    for (int p = 0; p < NUM_PORTS; p++) begin
      portSel[p] = inRange && (addr[ADDR_W-1:1] == (ADDR_W-1)'(p));
    end
    stb.wrData  = wrEn && inRange && !addr[0];
    stb.wrDir   = wrEn && inRange && addr[0];
    stb.rdDir   = addr[0];
    stb.rdValid = inRange;
  end
endmodule

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int PORT_W    = 4,
  parameter int OD_BIT    = 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  gpioStrobe_t                   stb,
  input  logic [NUM_PORTS-1:0]          portSel,
  input  logic [PORT_W-1:0]             wrData,
  input  logic [NUM_PORTS*PORT_W-1:0]   padSync,
  input  logic [NUM_PORTS*PORT_W-1:0]   altEn,
  input  logic [NUM_PORTS*PORT_W-1:0]   altOe,
  input  logic [NUM_PORTS*PORT_W-1:0]   altOut,
  output logic [PORT_W-1:0]             rdData,
  output logic [NUM_PORTS*PORT_W-1:0]   padOut,
  output logic [NUM_PORTS*PORT_W-1:0]   padOe
);
  localparam int TOTAL = NUM_PORTS * PORT_W;

  logic [TOTAL-1:0] latchQ;
  logic [TOTAL-1:0] dirQ;
  logic [TOTAL-1:0] useLatch;
  logic [TOTAL-1:0] bitView;

  // latch and direction storage; latch writable in any mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '0;
      dirQ   <= '0;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (portSel[p] && stb.wrData) latchQ[p*PORT_W +: PORT_W] <= wrData;
        if (portSel[p] && stb.wrDir)  dirQ[p*PORT_W +: PORT_W]   <= wrData;
      end
    end
  end

  // per-bit pad driver: override, open-drain or push-pull
  for (genvar i = 0; i < TOTAL; i++) begin : g_pad
    logic ownOe;
    logic ownOut;
    if (i == OD_BIT) begin : g_od
      assign ownOe  = dirQ[i] && !latchQ[i];
      assign ownOut = 1'b0;
    end else begin : g_pp
      assign ownOe  = dirQ[i];
      assign ownOut = latchQ[i];
    end
    assign padOe[i]  = altEn[i] ? altOe[i]  : ownOe;
    assign padOut[i] = altEn[i] ? altOut[i] : ownOut;
  end

  // readback source chosen per bit
  assign useLatch = dirQ & ~altEn;
  assign bitView  = (useLatch & latchQ) | (~useLatch & padSync);

  always_comb begin
    rdData = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (portSel[p] && stb.rdValid) begin
        rdData = stb.rdDir ? dirQ[p*PORT_W +: PORT_W] : bitView[p*PORT_W +: PORT_W];
      end
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int PORT_W    = 4,
  parameter int OD_BIT    = 1,
  localparam int ADDR_W   = $clog2(NUM_PORTS) + 1,
  localparam int TOTAL    = NUM_PORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PORT_W-1:0] wrData,
  output logic [PORT_W-1:0] rdData,
  input  logic [TOTAL-1:0]  padIn,
  output logic [TOTAL-1:0]  padOut,
  output logic [TOTAL-1:0]  padOe,
  input  logic [TOTAL-1:0]  altEn,
  input  logic [TOTAL-1:0]  altOe,
  input  logic [TOTAL-1:0]  altOut
);
  gpioStrobe_t          stb;
  logic [NUM_PORTS-1:0] portSel;
  logic [TOTAL-1:0]     padSync;

  gpio_bank_ctrl #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) ctrl_i (
    .wrEn(wrEn), .addr(addr), .stb(stb), .portSel(portSel)
  );

  gpio_bank_sync #(.WIDTH(TOTAL)) sync_i (
    .clk(clk), .rstN(rstN), .asyncIn(padIn), .syncOut(padSync)
  );

  gpio_bank_dp #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .OD_BIT(OD_BIT)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .portSel(portSel), .wrData(wrData),
    .padSync(padSync), .altEn(altEn), .altOe(altOe), .altOut(altOut),
    .rdData(rdData), .padOut(padOut), .padOe(padOe)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NUM_PORTS = 3,
  parameter int PORT_W    = 4,
  parameter int OD_BIT    = 1,
  parameter int ADDR_W    = 3
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        wrEn,
  input logic [ADDR_W-1:0]           addr,
  input logic [PORT_W-1:0]           wrData,
  input logic [NUM_PORTS*PORT_W-1:0] padOut,
  input logic [NUM_PORTS*PORT_W-1:0] padOe,
  input logic [NUM_PORTS*PORT_W-1:0] altEn,
  input logic [NUM_PORTS*PORT_W-1:0] altOe,
  input logic [NUM_PORTS*PORT_W-1:0] altOut
);
  localparam int TOTAL = NUM_PORTS * PORT_W;

  for (genvar i = 0; i < TOTAL; i++) begin : g_bit
    localparam int PIDX = i / PORT_W;
    localparam int BIDX = i % PORT_W;

    assert_alt_drive_R8: assert property (@(posedge clk) disable iff (!rstN)
      altEn[i] |-> (padOe[i] == altOe[i] && padOut[i] == altOut[i]));

    if (i != OD_BIT) begin : g_pp
      assert_dir_sets_oe_R2: assert property (@(posedge clk) disable iff (!rstN)
        (wrEn && addr == ADDR_W'(2*PIDX+1) && !altEn[i])
          |=> (altEn[i] || padOe[i] == $past(wrData[BIDX])));

      assert_oe_rise_no_glitch_R5: assert property (@(posedge clk) disable iff (!rstN)
        (!altEn[i] && $past(!altEn[i]) && $rose(padOe[i])) |-> $stable(padOut[i]));
    end else begin : g_od
      assert_od_never_high_R7: assert property (@(posedge clk) disable iff (!rstN)
        (!altEn[i] && padOe[i]) |-> !padOut[i]);
    end
  end

  assert_oob_write_ignored_R11: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr >= ADDR_W'(2*NUM_PORTS))
      |=> (!$stable(altEn) || !$stable(altOe) || !$stable(altOut)
           || ($stable(padOe) && $stable(padOut))));
endmodule

bind gpio_bank gpio_bank_chk #(
  .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .OD_BIT(OD_BIT), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .padOut(padOut), .padOe(padOe), .altEn(altEn), .altOe(altOe), .altOut(altOut)
);

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
  localparam int NP = 3;
  localparam int PW = 4;
  localparam int OD = 1;
  localparam int AW = 3;
  localparam int TB = NP * PW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [PW-1:0] wrData = '0;
  logic [PW-1:0] rdData;
  logic [TB-1:0] padIn = '0;
  logic [TB-1:0] padOut;
  logic [TB-1:0] padOe;
  logic [TB-1:0] altEn = '0;
  logic [TB-1:0] altOe = '0;
  logic [TB-1:0] altOut = '0;

  logic [TB-1:0] mLatch = '0;
  logic [TB-1:0] mDir = '0;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  gpio_bank #(.NUM_PORTS(NP), .PORT_W(PW), .OD_BIT(OD)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .altEn(altEn), .altOe(altOe), .altOut(altOut)
  );

  function automatic logic [PW-1:0] expRead(int p);
    logic [PW-1:0] r;
    for (int b = 0; b < PW; b++) begin
      int i = p*PW + b;
      r[b] = (mDir[i] && !altEn[i]) ? mLatch[i] : padIn[i];
    end
    return r;
  endfunction

  function automatic logic [TB-1:0] expOe();
    logic [TB-1:0] r;
    for (int i = 0; i < TB; i++)
      r[i] = altEn[i] ? altOe[i] : (i == OD ? (mDir[i] && !mLatch[i]) : mDir[i]);
    return r;
  endfunction

  function automatic logic [TB-1:0] expOut();
    logic [TB-1:0] r;
    for (int i = 0; i < TB; i++)
      r[i] = altEn[i] ? altOut[i] : (i == OD ? 1'b0 : mLatch[i]);
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(int a, logic [PW-1:0] d);
    addr = AW'(a); wrData = d; wrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
    if (a < 2*NP) begin
      if (a % 2 == 0) mLatch[(a/2)*PW +: PW] = d;
      else            mDir[(a/2)*PW +: PW]   = d;
    end
  endtask

  task automatic regRead(int a, output logic [PW-1:0] d);
    addr = AW'(a); #1; d = rdData;
  endtask

  task automatic checkPads(string tag);
    #1;
    check({tag, " oe"}, 32'(padOe), 32'(expOe()));
    check({tag, " out"}, 32'(padOut), 32'(expOut()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [PW-1:0] rv;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    checkPads("R1 reset");
    for (int a = 0; a < 2*NP; a++) begin
      regRead(a, rv); check("R1 reset read", 32'(rv), 0);
    end

    // R2 R3 R4 R7 R10: sweep direction x latch on every port
    for (int p = 0; p < NP; p++) begin
      for (int dv = 0; dv < 16; dv++) begin
        for (int lv = 0; lv < 16; lv++) begin
          padIn[p*PW +: PW] = PW'(lv) ^ 4'b0110;
          regWrite(2*p, PW'(lv));
          regWrite(2*p+1, PW'(dv));
          regRead(2*p, rv);   check("R3,R4 data read", 32'(rv), 32'(expRead(p)));
          regRead(2*p+1, rv); check("R10 dir read", 32'(rv), 32'(dv));
          checkPads("R2,R7 pads");
        end
      end
      regWrite(2*p+1, '0);
    end

    // R4: two-edge synchronizer latency on port 2 (inputs)
    padIn[8 +: 4] = 4'b0000;
    repeat (3) @(negedge clk);
    padIn[8 +: 4] = 4'b1111;
    @(negedge clk);
    regRead(4, rv); check("R4 one edge old value", 32'(rv), 32'h0);
    @(negedge clk);
    regRead(4, rv); check("R4 two edges new value", 32'(rv), 32'hf);

    // R5: load latch while input, then turn output; padOut already shows latch
    regWrite(3, 4'b0000);
    regWrite(2, 4'b1010);
    checkPads("R5 latch in input mode");
    check("R5 padOut before dir", 32'(padOut[7:4]), 32'hA);
    regWrite(3, 4'b1111);
    check("R5 padOut after dir", 32'(padOut[7:4]), 32'hA);
    check("R5 padOe after dir", 32'(padOe[7:4]), 32'hF);

    // R6: read-modify-write copies input pins into latches
    regWrite(2, 4'b0000);
    regWrite(3, 4'b0011);
    padIn[7:4] = 4'b1100;
    repeat (2) @(negedge clk);
    regRead(2, rv); check("R6 mixed read", 32'(rv), 32'hC);
    regWrite(2, rv | 4'b0001);
    padIn[7:4] = 4'b0000;
    regWrite(3, 4'b1111);
    regRead(2, rv); check("R6 latch took pin levels", 32'(rv), 32'hD);
    checkPads("R6 pads");

    // R7: open-drain pin directed output, latch 0 then 1
    regWrite(1, 4'b0010);
    regWrite(0, 4'b0000);
    check("R7 od drives low oe", 32'(padOe[OD]), 1);
    check("R7 od drives low out", 32'(padOut[OD]), 0);
    regWrite(0, 4'b0010);
    check("R7 od released", 32'(padOe[OD]), 0);
    regRead(0, rv); check("R7 od reads latch", 32'(rv[1]), 1);

    // R8 R9: override sweep on port 2 and on the open-drain bit
    regWrite(5, 4'b1111);
    regWrite(4, 4'b0101);
    padIn[8 +: 4] = 4'b1001;
    padIn[OD] = 1'b0;
    for (int v = 0; v < 16; v++) begin
      altEn[8 +: 4] = PW'(v);
      altOe[8 +: 4] = 4'b1011;
      altOut[8 +: 4] = PW'(v) ^ 4'b1110;
      altEn[OD] = v[0];
      altOe[OD] = 1'b1;
      altOut[OD] = 1'b1;
      repeat (2) @(negedge clk);
      checkPads("R8 override pads");
      regRead(4, rv); check("R9 override read", 32'(rv), 32'(expRead(2)));
      regRead(0, rv); check("R9 override read od", 32'(rv), 32'(expRead(0)));
    end
    altEn = '0;

    // R11: out-of-range writes and reads
    regWrite(6, 4'b1111);
    regWrite(7, 4'b1111);
    checkPads("R11 pads unchanged");
    for (int a = 0; a < 2*NP; a += 2) begin
      regRead(a, rv); check("R11 data unchanged", 32'(rv), 32'(expRead(a/2)));
      regRead(a+1, rv); check("R11 dir unchanged", 32'(rv), 32'(mDir[(a/2)*PW +: PW]));
    end
    regRead(6, rv); check("R11 read zero", 32'(rv), 0);
    regRead(7, rv); check("R11 read zero", 32'(rv), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule